// File: doc/BRIEF.md
# DRAM Controller Event Counter Bank

This block is a bank of performance counters that sits beside a DRAM controller. Software reaches it through a 64-bit register port: it picks the events each programmable counter watches, arms and halts counters, clears them and reads back their values. The controller feeds the bank a 63-bit bus of single-cycle event pulses, plus one strobe for each DRAM read and one for each DRAM write.

There are eight programmable counters and two fixed ones. Each programmable counter selects its events through a bitmap in which bit e-1 stands for event e. A few bit positions select a 4-bit group of event lines instead of a single line; such a group adds the number of its lines that pulse. The two fixed counters count the read strobe and the write strobe. No counter wraps. A counter that reaches all-ones holds that value and raises a sticky status bit until it is started again or cleared.

Top module: `mcev_bank`

## Requirements
- R1: After reset every counter value, configuration, mode, fixed enable and status bit reads as zero.
- R2: Configuration register n is at byte offset 0x000+8n. Bits 62:0 are the event bitmap and bit 63 enables the counter; the whole word reads back as written. A counter whose bit 63 is clear holds its value.
- R3: Bitmap bit k outside any group selects event line k. A counter adds exactly 1 in a cycle where one or more of its selected single lines pulse.
- R4: Bitmap bits 16 and 20 are group starts. Setting one of them selects event lines 19:16 or 23:20, and the counter adds the number of set lines in that group (0 to 4) in that cycle, on top of any single-line hit.
- R5: Mode register n is at 0x040+8n, bit 0. When it is 1 (manual), an enabled counter counts only between a start and a stop. When it is 0, an enabled counter counts whenever its enable is set.
- R6: Writing bit 0 = 1 to 0x080+8n starts counter n, but only if it is not already running. A start zeroes the value, clears the sticky bit and marks the counter running. Writing bit 0 = 1 to 0x0C0+8n stops it. Counter values are read at 0x100+8n.
- R7: A counter that reaches all-ones stays there and sets status bit n at 0x160. The value and the bit hold until a stop followed by a start.
- R8: The fixed enable register at 0x140 uses bit 0 for the write counter and bit 1 for the read counter. The write value is read at 0x150 and the read value at 0x158. Each counter adds 1 per cycle in which its strobe is high.
- R9: Writing 0x148 with bit 0 or bit 1 set zeroes the write or read fixed counter and its status bit (bit 8 or bit 9 of 0x160). A clear wins over a strobe in the same cycle. The fixed counters also saturate at all-ones and set their status bit.
- R10: Reads of unmapped or misaligned offsets, and of the write-only start, stop and clear registers, return zero. Writes to unmapped or misaligned offsets change nothing.
- R11: Read data appears on the output one cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| evt_bus | input | 63 | Per-cycle event pulses, line k is event k+1 |
| dram_rd_evt | input | 1 | One DRAM read this cycle |
| dram_wr_evt | input | 1 | One DRAM write this cycle |

## Verification
Two cases can land in one cycle: a fixed-counter clear and a strobe on that counter, and a saturated counter together with a restart or a redundant start. The bench writes the read-counter clear while the read strobe is high and expects zero, not one, on the next read. It also sends a start to a counter that is saturated and still running, expects the frozen all-ones value to survive, and then expects a stop followed by a start to bring back zero with the status bit clear.

// File: rtl/mcev_pkg.sv
package mcev_pkg;

  localparam int REG_W   = 64;
  localparam int EVT_W   = REG_W - 1;
  localparam int FIELD_W = 4;
  localparam int ADDR_W  = 12;

  localparam logic [5:0] RG_CFG   = 6'd0;
  localparam logic [5:0] RG_MODE  = 6'd1;
  localparam logic [5:0] RG_START = 6'd2;
  localparam logic [5:0] RG_STOP  = 6'd3;
  localparam logic [5:0] RG_VAL   = 6'd4;
  localparam logic [5:0] RG_MISC  = 6'd5;

  localparam logic [2:0] SUB_FEN  = 3'd0;
  localparam logic [2:0] SUB_FCLR = 3'd1;
  localparam logic [2:0] SUB_FWR  = 3'd2;
  localparam logic [2:0] SUB_FRD  = 3'd3;
  localparam logic [2:0] SUB_STAT = 3'd4;

  localparam logic [EVT_W-1:0] DEF_FIELD_STARTS = EVT_W'((64'd1 << 16) | (64'd1 << 20));

  function automatic logic [EVT_W-1:0] field_cover(input logic [EVT_W-1:0] starts);
    logic [EVT_W+FIELD_W-2:0] acc;
    acc = '0;
    for (int i = 0; i < EVT_W; i++) begin
      if (starts[i]) begin
        for (int j = 0; j < FIELD_W; j++) acc[i+j] = 1'b1;
      end
    end
    return acc[EVT_W-1:0];
  endfunction

  function automatic int count_ones(input logic [EVT_W-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < EVT_W; i++) c = c + int'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/mcev_rst_sync.sv
module mcev_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mcev_incr.sv
module mcev_incr import mcev_pkg::*; #(
  parameter logic [EVT_W-1:0] FIELD_STARTS = DEF_FIELD_STARTS,
  parameter int INC_W = 4
) (
  input  logic [EVT_W-1:0] sel,
  input  logic [EVT_W-1:0] evt,
  output logic [INC_W-1:0] inc
);
  localparam logic [EVT_W-1:0] COVER = field_cover(FIELD_STARTS);

  logic [EVT_W+FIELD_W-2:0] evt_pad;
  logic                     single_hit;
  logic [INC_W-1:0]         field_sum;

  always_comb begin
    evt_pad    = {{(FIELD_W-1){1'b0}}, evt};
    single_hit = |(evt & sel & ~COVER);
    field_sum  = '0;
    for (int i = 0; i < EVT_W; i++) begin
      if (FIELD_STARTS[i] && sel[i]) begin
        for (int j = 0; j < FIELD_W; j++) begin
          field_sum = field_sum + INC_W'(evt_pad[i+j]);
        end
      end
    end
    inc = field_sum + INC_W'(single_hit);
  end
endmodule

// File: rtl/mcev_satcnt.sv
module mcev_satcnt #(
  parameter int W     = 64,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt,
  output logic             at_max
);
  localparam int SW = ((W > INC_W) ? W : INC_W) + 1;
  localparam logic [SW-1:0] TOP = SW'({W{1'b1}});

  logic [W-1:0]  cnt_q, cnt_d;
  logic          max_q, max_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum   = SW'(cnt_q) + SW'(inc);
    cnt_d = cnt_q;
    max_d = max_q;
    if (clr) begin
      cnt_d = '0;
      max_d = 1'b0;
    end else if (en && !max_q) begin
      if (sum >= TOP) begin
        cnt_d = '1;
        max_d = 1'b1;
      end else begin
        cnt_d = W'(sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      max_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      max_q <= max_d;
    end
  end

  assign cnt    = cnt_q;
  assign at_max = max_q;
endmodule

// File: rtl/mcev_bank.sv
module mcev_bank import mcev_pkg::*; #(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 64,
  parameter logic [EVT_W-1:0] FIELD_STARTS = DEF_FIELD_STARTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [EVT_W-1:0]  evt_bus,
  input  logic              dram_rd_evt,
  input  logic              dram_wr_evt
);
  localparam int NFLD    = count_ones(FIELD_STARTS);
  localparam int MAX_INC = 1 + FIELD_W * NFLD;
  localparam int INC_W   = $clog2(MAX_INC + 1);

  logic rst_n_int;

  mcev_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  // address decode
  logic       aligned;
  logic [5:0] region;
  logic [2:0] sub;

  assign aligned = (reg_addr[2:0] == 3'b000);
  assign region  = reg_addr[11:6];
  assign sub     = reg_addr[5:3];

  // per-channel state brought out of the generate scopes
  logic [REG_W-1:0]                cfg_all [NUM_PROG];
  logic [NUM_PROG-1:0]             mode_all;
  logic [NUM_PROG-1:0]             p_start;
  logic [NUM_PROG-1:0]             p_cnten;
  logic [NUM_PROG-1:0]             p_max;
  logic [NUM_PROG-1:0][CNT_W-1:0]  p_cnt;

  for (genvar n = 0; n < NUM_PROG; n++) begin : g_chan
    logic             hit_cfg, hit_mode, hit_start, hit_stop;
    logic             stop_cmd;
    logic [REG_W-1:0] cfg_q, cfg_d;
    logic             mode_q, mode_d;
    logic             run_q, run_d;
    logic [INC_W-1:0] inc;

    assign hit_cfg   = reg_wr && aligned && (region == RG_CFG)   && (32'(sub) == n);
    assign hit_mode  = reg_wr && aligned && (region == RG_MODE)  && (32'(sub) == n);
    assign hit_start = reg_wr && aligned && (region == RG_START) && (32'(sub) == n);
    assign hit_stop  = reg_wr && aligned && (region == RG_STOP)  && (32'(sub) == n);

    assign p_start[n] = hit_start && reg_wdata[0] && !run_q;
    assign stop_cmd   = hit_stop && reg_wdata[0];
    assign p_cnten[n] = cfg_q[REG_W-1] && (run_q || !mode_q);

    always_comb begin
      cfg_d  = cfg_q;
      mode_d = mode_q;
      run_d  = run_q;
      if (hit_cfg)  cfg_d  = reg_wdata;
      if (hit_mode) mode_d = reg_wdata[0];
      if (p_start[n])    run_d = 1'b1;
      else if (stop_cmd) run_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int) begin
        cfg_q  <= '0;
        mode_q <= 1'b0;
        run_q  <= 1'b0;
      end else begin
        cfg_q  <= cfg_d;
        mode_q <= mode_d;
        run_q  <= run_d;
      end
    end

    mcev_incr #(
      .FIELD_STARTS (FIELD_STARTS),
      .INC_W        (INC_W)
    ) u_incr (
      .sel (cfg_q[EVT_W-1:0]),
      .evt (evt_bus),
      .inc (inc)
    );

    mcev_satcnt #(
      .W     (CNT_W),
      .INC_W (INC_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .clr    (p_start[n]),
      .en     (p_cnten[n]),
      .inc    (inc),
      .cnt    (p_cnt[n]),
      .at_max (p_max[n])
    );

    assign cfg_all[n]  = cfg_q;
    assign mode_all[n] = mode_q;
  end

  // fixed counters: index 0 = writes, 1 = reads
  logic       hit_fen, hit_fclr;
  logic [1:0] fen_q, fen_d;
  logic [1:0] f_clr;
  logic [CNT_W-1:0] f_cnt_wr, f_cnt_rd;
  logic       f_max_wr, f_max_rd;

  assign hit_fen  = reg_wr && aligned && (region == RG_MISC) && (sub == SUB_FEN);
  assign hit_fclr = reg_wr && aligned && (region == RG_MISC) && (sub == SUB_FCLR);
  assign f_clr    = {2{hit_fclr}} & reg_wdata[1:0];

  always_comb begin
    fen_d = fen_q;
    if (hit_fen) fen_d = reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) fen_q <= 2'b00;
    else            fen_q <= fen_d;
  end

  mcev_satcnt #(.W(CNT_W), .INC_W(1)) u_fix_wr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (f_clr[0]),
    .en     (fen_q[0]),
    .inc    (dram_wr_evt),
    .cnt    (f_cnt_wr),
    .at_max (f_max_wr)
  );

  mcev_satcnt #(.W(CNT_W), .INC_W(1)) u_fix_rd (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr    (f_clr[1]),
    .en     (fen_q[1]),
    .inc    (dram_rd_evt),
    .cnt    (f_cnt_rd),
    .at_max (f_max_rd)
  );

  // read path
  logic [REG_W-1:0] status;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rdata_q, rdata_d;

  always_comb begin
    status = '0;
    status[NUM_PROG-1:0] = p_max;
    status[8] = f_max_wr;
    status[9] = f_max_rd;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (region)
        RG_CFG: begin
          for (int n = 0; n < NUM_PROG; n++) if (32'(sub) == n) rd_mux = cfg_all[n];
        end
        RG_MODE: begin
          for (int n = 0; n < NUM_PROG; n++) if (32'(sub) == n) rd_mux = REG_W'(mode_all[n]);
        end
        RG_VAL: begin
          for (int n = 0; n < NUM_PROG; n++) if (32'(sub) == n) rd_mux = REG_W'(p_cnt[n]);
        end
        RG_MISC: begin
          case (sub)
            SUB_FEN:  rd_mux = REG_W'(fen_q);
            SUB_FWR:  rd_mux = REG_W'(f_cnt_wr);
            SUB_FRD:  rd_mux = REG_W'(f_cnt_rd);
            SUB_STAT: rd_mux = status;
            default:  rd_mux = '0;
          endcase
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (reg_rd) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/mcev_bank_chk.sv
module mcev_bank_chk #(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 64
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            rd_en,
  input logic [11:0]                     addr,
  input logic [63:0]                     rdata,
  input logic [NUM_PROG-1:0][CNT_W-1:0]  p_cnt,
  input logic [NUM_PROG-1:0]             p_max,
  input logic [NUM_PROG-1:0]             p_start,
  input logic [NUM_PROG-1:0]             p_cnten,
  input logic [CNT_W-1:0]                f_cnt_wr,
  input logic [CNT_W-1:0]                f_cnt_rd,
  input logic [1:0]                      f_clr
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_chk
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_cnt[i] == CMAX && !p_start[i]) |=> (p_cnt[i] == CMAX));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      p_max[i] |-> (p_cnt[i] == CMAX));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_cnten[i] && !p_start[i]) |=> $stable(p_cnt[i]));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      p_start[i] |=> (p_cnt[i] == '0 && !p_max[i]));
  end

  p_fclr_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    f_clr[0] |=> (f_cnt_wr == '0));

  p_fclr_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    f_clr[1] |=> (f_cnt_rd == '0));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= 12'h168) |=> (rdata == 64'd0));
endmodule

bind mcev_bank mcev_bank_chk #(
  .NUM_PROG (NUM_PROG),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .rd_en    (reg_rd),
  .addr     (reg_addr),
  .rdata    (reg_rdata),
  .p_cnt    (p_cnt),
  .p_max    (p_max),
  .p_start  (p_start),
  .p_cnten  (p_cnten),
  .f_cnt_wr (f_cnt_wr),
  .f_cnt_rd (f_cnt_rd),
  .f_clr    (f_clr)
);

// File: tb/test_mcev_bank.sv
module test_mcev_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam logic [63:0] EN = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [62:0] evt_bus = '0;
  logic        dram_rd_evt = 1'b0;
  logic        dram_wr_evt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcev_bank #(.CNT_W(CW)) i_mcev_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .evt_bus     (evt_bus),
    .dram_rd_evt (dram_rd_evt),
    .dram_wr_evt (dram_wr_evt)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) rd_d <= reg_rd;

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin : mon
    logic [63:0] e;
    string t;
    if (rd_d) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [62:0] e, input logic r, input logic w, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evt_bus = e; dram_rd_evt = r; dram_wr_evt = w;
    end
    @(negedge clk);
    evt_bus = '0; dram_rd_evt = 1'b0; dram_wr_evt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state (read latency R11 implied by every check)
    rd(12'h000, 64'd0, "R1 cfg0");
    rd(12'h100, 64'd0, "R1 value0");
    rd(12'h160, 64'd0, "R1 status");
    rd(12'h140, 64'd0, "R1 fixed enable");
    rd(12'h158, 64'd0, "R1 R11 read counter");

    // R3 single lines, auto mode
    wr(12'h000, EN | 64'h24);
    pulse(63'h4, 1'b0, 1'b0, 3);
    pulse(63'h24, 1'b0, 1'b0, 1);
    pulse(63'h80, 1'b0, 1'b0, 2);
    rd(12'h100, 64'd4, "R3 single-line count");

    // R2 disable holds value, read back
    wr(12'h000, 64'h24);
    pulse(63'h4, 1'b0, 1'b0, 3);
    rd(12'h100, 64'd4, "R2 disabled counter holds");
    rd(12'h000, 64'h24, "R2 config readback");

    // R4 R5 groups in manual mode
    wr(12'h048, 64'd1);
    wr(12'h008, EN | (64'd1 << 16) | (64'd1 << 20) | 64'd1);
    rd(12'h048, 64'd1, "R5 mode readback");
    pulse(63'hB << 16, 1'b0, 1'b0, 2);
    rd(12'h108, 64'd0, "R5 manual counter idle before start");
    wr(12'h088, 64'd1);
    pulse((63'h6 << 20) | (63'hB << 16) | 63'h1, 1'b0, 1'b0, 1);
    pulse(63'h1 << 17, 1'b0, 1'b0, 1);
    pulse(63'h1, 1'b0, 1'b0, 1);
    rd(12'h108, 64'd8, "R4 group popcount");
    wr(12'h0C8, 64'd1);
    pulse(63'h1, 1'b0, 1'b0, 3);
    rd(12'h108, 64'd8, "R5 stopped counter holds");

    // R6 R7 saturation on channel 3
    wr(12'h058, 64'd1);
    wr(12'h018, EN | (64'd1 << 16));
    wr(12'h098, 64'd1);
    pulse(63'hF << 16, 1'b0, 1'b0, 70);
    rd(12'h118, 64'hFF, "R7 saturated value");
    rd(12'h160, 64'h8, "R7 sticky status");
    wr(12'h098, 64'd1);
    rd(12'h118, 64'hFF, "R6 start while running ignored");
    wr(12'h0D8, 64'd1);
    wr(12'h098, 64'd1);
    rd(12'h118, 64'd0, "R6 stop then start zeroes");
    rd(12'h160, 64'd0, "R6 status cleared");
    pulse(63'hF << 16, 1'b0, 1'b0, 1);
    rd(12'h118, 64'd4, "R6 counts again after restart");

    // R8 fixed counters
    wr(12'h140, 64'd3);
    pulse('0, 1'b1, 1'b0, 5);
    pulse('0, 1'b0, 1'b1, 3);
    rd(12'h150, 64'd3, "R8 write counter");
    rd(12'h158, 64'd5, "R8 read counter");

    // R9 clear against same-cycle strobe
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h148; reg_wdata = 64'd2; dram_rd_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; dram_rd_evt = 1'b0;
    rd(12'h158, 64'd0, "R9 clear wins over strobe");
    rd(12'h150, 64'd3, "R9 other counter untouched");

    wr(12'h140, 64'd2);
    rd(12'h140, 64'd2, "R8 enable readback");
    pulse('0, 1'b1, 1'b1, 2);
    rd(12'h150, 64'd3, "R8 disabled write counter holds");
    rd(12'h158, 64'd2, "R8 read counter counts");
    pulse('0, 1'b1, 1'b0, 300);
    rd(12'h158, 64'hFF, "R9 fixed saturates");
    rd(12'h160, 64'h200, "R9 fixed status bit");
    wr(12'h148, 64'd2);
    rd(12'h158, 64'd0, "R9 clear after saturation");
    rd(12'h160, 64'd0, "R9 status cleared");

    // R10 unmapped and write-only
    wr(12'h1F8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h1F8, 64'd0, "R10 unmapped read");
    rd(12'h088, 64'd0, "R10 start reg reads zero");
    rd(12'h148, 64'd0, "R10 clear reg reads zero");
    wr(12'h00C, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h000, 64'h24, "R10 misaligned write ignored");
    rd(12'h00C, 64'd0, "R10 misaligned read");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule